// File: doc/BRIEF.md
# Instruction Cache Fetch Controller

This block stands between a processor's instruction-fetch port and a word-wide memory bus. It keeps a small set-associative store of eight-word lines. Each fetch that the cache may serve is looked up by tag. A hit is answered in the cycle the request is presented. A miss refills a whole line from the bus and then answers with the requested word.

Fetches that must not be cached are passed to the bus as one single-word read each. This covers a fetch from a region marked non-cacheable while translation is on, every fetch while the cache is switched off, and a miss when every way is locked. The refill victim is drawn only from unlocked ways. A mode input picks between a free-running pseudo-random source and a round-robin pointer. Stored lines survive a disable and re-enable. A one-cycle pulse invalidates the whole store.

Addresses are word addresses. Bits [2:0] select the word in a line, the next log2(SETS) bits select the set, and the remaining upper bits form the tag. WAYS and SETS must be powers of two, with at least two of each.

Top module: `icache_fetch_ctrl`

## Requirements
- R1: After reset the cache is switched off and every line is invalid, so the first cacheable fetch after switching on misses and refills.
- R2: A cycle with cfg_we high loads cfg_en into the enable bit. Switching off and back on leaves stored lines intact, and a later hit returns the word captured at refill even if memory has since changed.
- R3: While the cache is off, every fetch makes exactly one bus read at the fetch address and returns the bus data, even when a matching line is stored. Nothing is allocated.
- R4: While mmu_on is low, f_cacheable is ignored and every fetch is handled as cacheable: a miss refills and a repeat fetch hits.
- R5: With the cache on, a cacheable hit raises f_done in the same cycle as f_req, with the stored word, and makes no bus request.
- R6: A cacheable miss makes eight bus reads of the line at word offsets 0,1,...,7 in that order. f_done rises in the cycle after the eighth read is accepted and carries the requested word. Later fetches to any word of that line hit.
- R7: With mmu_on high and f_cacheable low, a fetch makes exactly one bus read and returns the bus data, even if the line is stored. Nothing is allocated.
- R8: The refill victim is always a way whose lock_mask bit is 0 (bit w locks way w), in both modes. If all ways are locked, a miss is served as a single bus read with no allocation, and stored lines still hit.
- R9: With rr_mode high, the victim is the first unlocked way at or after a pointer, counting upward with wrap-around. The pointer is 0 after reset and becomes victim+1 after each refill.
- R10: A one-cycle inv_all pulse clears every valid bit, so the next cacheable fetch misses.
- R11: Once m_req is high, m_req and m_addr hold steady until a cycle with m_rdy high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load strobe for the enable bit |
| cfg_en | input | 1 | New value of the enable bit |
| mmu_on | input | 1 | Address translation active; when low, every fetch is cacheable |
| rr_mode | input | 1 | 1 = round-robin victim, 0 = pseudo-random victim |
| inv_all | input | 1 | Pulse that invalidates every line |
| lock_mask | input | WAYS | Per-way lock; bit w set keeps way w from replacement |
| f_req | input | 1 | Fetch request, held until f_done |
| f_addr | input | ADDR_W | Fetch word address |
| f_cacheable | input | 1 | Cacheable attribute of the fetch |
| f_done | output | 1 | Fetch answered this cycle |
| f_data | output | DATA_W | Fetched word, valid with f_done |
| m_req | output | 1 | Bus read request |
| m_addr | output | ADDR_W | Bus read word address |
| m_rdy | input | 1 | Bus read accepted, m_data valid |
| m_data | input | DATA_W | Bus read data |

## Verification
The bench builds the block with four ways and only four sets on 16-bit addresses. Tags range over a handful of values, so random fetches hit, miss and evict often, and a single set can be filled and overflowed by five directed refills. This makes round-robin wrap-around, eviction of a specific line, and every lock pattern up to all-locked reachable within a few hundred fetches. The bus model adds random wait states, which exercises the hold rule on the request.

// File: rtl/icache_fetch_ctrl.sv
module icache_fetch_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WAYS   = 4,
  parameter int SETS   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_en,
  input  logic              mmu_on,
  input  logic              rr_mode,
  input  logic              inv_all,
  input  logic [WAYS-1:0]   lock_mask,
  input  logic              f_req,
  input  logic [ADDR_W-1:0] f_addr,
  input  logic              f_cacheable,
  output logic              f_done,
  output logic [DATA_W-1:0] f_data,
  output logic              m_req,
  output logic [ADDR_W-1:0] m_addr,
  input  logic              m_rdy,
  input  logic [DATA_W-1:0] m_data
);
  localparam int WB = $clog2(WAYS);
  localparam int IW = $clog2(SETS);
  localparam int TW = ADDR_W - 3 - IW;
  localparam int LW = WB + IW + 3;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_SINGLE, S_RESP} st_t;

  st_t               state, state_d;
  logic              en_q;
  logic [WAYS-1:0]   vld [SETS];
  logic [TW-1:0]     tag_q [SETS][WAYS];
  logic [DATA_W-1:0] mem [1<<LW];
  logic [WB-1:0]     rr_ptr, way_q, hit_way, vict, start, cand;
  logic [7:0]        lfsr;
  logic [ADDR_W-1:0] a_q;
  logic [2:0]        cnt_q;
  logic [DATA_W-1:0] rdata_q;
  logic              hit, vict_ok, eff_c, take_hit, vld_any;

  wire [IW-1:0] f_idx = f_addr[3 +: IW];
  wire [TW-1:0] f_tag = f_addr[ADDR_W-1 -: TW];
  wire [IW-1:0] a_idx = a_q[3 +: IW];

  assign eff_c    = !mmu_on || f_cacheable;
  assign take_hit = state == S_IDLE && f_req && en_q && eff_c && hit;
  assign f_done   = take_hit || state == S_RESP;
  assign f_data   = (state == S_RESP) ? rdata_q : mem[{hit_way, f_idx, f_addr[2:0]}];
  assign m_req    = state == S_FILL || state == S_SINGLE;
  assign m_addr   = (state == S_FILL) ? {a_q[ADDR_W-1:3], cnt_q} : a_q;
  assign start    = rr_mode ? rr_ptr : lfsr[WB-1:0];

  always_comb begin
    hit = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (vld[f_idx][w] && tag_q[f_idx][w] == f_tag) begin
        hit = 1'b1;
        hit_way = WB'(w);
      end
  end

  always_comb begin
    vict_ok = 1'b0;
    vict = '0;
    cand = '0;
    for (int i = 0; i < WAYS; i++) begin
      cand = start + WB'(i);
      if (!vict_ok && !lock_mask[cand]) begin
        vict = cand;
        vict_ok = 1'b1;
      end
    end
  end

  always_comb begin
    vld_any = 1'b0;
    for (int s = 0; s < SETS; s++) vld_any = vld_any || (|vld[s]);
  end

  always_comb begin
    state_d = state;
    case (state)
      S_IDLE:   if (f_req && !take_hit)
                  state_d = (en_q && eff_c && vict_ok) ? S_FILL : S_SINGLE;
      S_FILL:   if (m_rdy && cnt_q == 3'd7) state_d = S_RESP;
      S_SINGLE: if (m_rdy) state_d = S_RESP;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      en_q    <= 1'b0;
      rr_ptr  <= '0;
      lfsr    <= 8'h01;
      a_q     <= '0;
      way_q   <= '0;
      cnt_q   <= '0;
      rdata_q <= '0;
      for (int s = 0; s < SETS; s++) vld[s] <= '0;
    end else begin
      state <= state_d;
      lfsr  <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (cfg_we) en_q <= cfg_en;
      if (state == S_IDLE && state_d != S_IDLE) begin
        a_q   <= f_addr;
        way_q <= vict;
        cnt_q <= '0;
        if (state_d == S_FILL) vld[f_idx][vict] <= 1'b0;
      end
      if (state == S_FILL && m_rdy) begin
        cnt_q <= cnt_q + 3'd1;
        if (cnt_q == a_q[2:0]) rdata_q <= m_data;
        if (cnt_q == 3'd7) begin
          vld[a_idx][way_q] <= 1'b1;
          rr_ptr <= way_q + 1'b1;
        end
      end
      if (state == S_SINGLE && m_rdy) rdata_q <= m_data;
      if (inv_all)
        for (int s = 0; s < SETS; s++) vld[s] <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_IDLE && state_d == S_FILL) tag_q[f_idx][vict] <= f_tag;
    if (state == S_FILL && m_rdy) mem[{way_q, a_idx, cnt_q}] <= m_data;
  end

  a_r3_off_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !en_q) |-> !f_done);

  a_r6_beat_order: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FILL && m_rdy && m_addr[2:0] != 3'd7) |=>
      (state == S_FILL && m_addr[2:0] == $past(m_addr[2:0]) + 3'd1));

  a_r6_fill_end: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FILL && m_rdy && m_addr[2:0] == 3'd7) |=> f_done);

  a_r8_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && state_d == S_FILL) |-> !lock_mask[vict]);

  a_r10_inv_clear: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !vld_any);

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_rdy) |=> (m_req && $stable(m_addr)));
endmodule

// File: tb/icache_fetch_ctrl_bench.sv
`timescale 1ns/1ps
module icache_fetch_ctrl_bench;
  logic clk = 0, rst_n = 0, cfg_we = 0, cfg_en = 0, mmu_on = 1, rr_mode = 1, inv_all = 0;
  logic [3:0] lock_mask = '0;
  logic f_req = 0, f_cacheable = 0, f_done, m_req, m_rdy = 0;
  logic [15:0] f_addr = '0, m_addr;
  logic [31:0] f_data, m_data = '0, gen = '0;
  int total = 0, bad = 0, nreads = 0, wait_cnt = 0, hold_bad = 0;
  logic [15:0] alog [16];
  logic prev_req = 0, prev_rdy = 0;
  logic [15:0] prev_addr = '0;

  always #2 clk = ~clk;

  icache_fetch_ctrl #(.ADDR_W(16), .DATA_W(32), .WAYS(4), .SETS(4)) u_icache_fetch_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en), .mmu_on(mmu_on),
    .rr_mode(rr_mode), .inv_all(inv_all), .lock_mask(lock_mask), .f_req(f_req),
    .f_addr(f_addr), .f_cacheable(f_cacheable), .f_done(f_done), .f_data(f_data),
    .m_req(m_req), .m_addr(m_addr), .m_rdy(m_rdy), .m_data(m_data));

  function automatic [31:0] mv(input [15:0] a);
    return {a ^ 16'hc3a5, ~a} ^ gen;
  endfunction

  function automatic [15:0] ad(input int t, input int s, input int o);
    return 16'(t * 32 + s * 8 + o);
  endfunction

  always @(negedge clk) begin
    if (prev_req && !prev_rdy && (!m_req || m_addr != prev_addr)) hold_bad++;
    if (m_req) begin
      if (wait_cnt == 0) begin
        m_rdy = 1;
        m_data = mv(m_addr);
        alog[nreads & 15] = m_addr;
        nreads++;
        wait_cnt = $urandom % 3;
      end else begin
        m_rdy = 0;
        wait_cnt--;
      end
    end else m_rdy = 0;
    prev_req = m_req;
    prev_rdy = m_rdy;
    prev_addr = m_addr;
  end

  task automatic chk(input bit ok, input string req, input [31:0] act, input [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fetch(input [15:0] a, input bit c, output [31:0] d, output int nrd, output int lat);
    int n0;
    @(negedge clk);
    n0 = nreads;
    f_addr = a;
    f_cacheable = c;
    f_req = 1;
    lat = 0;
    forever begin
      #1;
      if (f_done) break;
      @(negedge clk);
      lat++;
    end
    d = f_data;
    nrd = nreads - n0;
    @(negedge clk);
    f_req = 0;
  endtask

  task automatic set_en(input bit v);
    @(negedge clk);
    cfg_we = 1;
    cfg_en = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic fx(input [15:0] a, input bit c, input int exp_n, input string req);
    logic [31:0] d;
    int n, l;
    fetch(a, c, d, n, l);
    chk(n == exp_n, req, n, exp_n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n, l, n0;
    logic [15:0] a;
    bit mval [4][4];
    int mtag [4][4];
    int rr;
    void'($urandom(1234));
    do_reset();
    #1;
    chk(f_done == 0 && m_req == 0, "R1 idle after reset", {f_done, m_req}, 0);

    a = ad(1, 0, 3);
    fetch(a, 1, d, n, l);
    chk(n == 1, "R3 off single read", n, 1);
    chk(d == mv(a), "R3 off data", d, mv(a));
    set_en(1);
    n0 = nreads;
    fetch(a, 1, d, n, l);
    chk(n == 8, "R1 first fetch misses", n, 8);
    chk(d == mv(a), "R6 miss data", d, mv(a));
    for (int i = 0; i < 8; i++)
      chk(alog[(n0 + i) & 15] == ad(1, 0, i), "R6 beat order", alog[(n0 + i) & 15], ad(1, 0, i));
    fetch(ad(1, 0, 5), 1, d, n, l);
    chk(n == 0 && l == 0, "R5 hit no bus same cycle", n * 256 + l, 0);
    chk(d == mv(ad(1, 0, 5)), "R5 hit data", d, mv(ad(1, 0, 5)));

    gen = 32'h1234_5678;
    set_en(0);
    fetch(a, 1, d, n, l);
    chk(n == 1 && d == mv(a), "R3 stored line ignored", d, mv(a));
    set_en(1);
    fetch(a, 1, d, n, l);
    gen = 0;
    chk(n == 0 && d == mv(a), "R2 line kept across disable", d, mv(a));
    gen = 32'h1234_5678;

    fetch(a, 0, d, n, l);
    chk(n == 1 && d == mv(a), "R7 noncacheable hit goes to bus", d, mv(a));
    fx(ad(2, 1, 0), 0, 1, "R7 single read");
    fx(ad(2, 1, 4), 1, 8, "R7 no allocation");

    mmu_on = 0;
    fx(ad(3, 1, 2), 0, 8, "R4 attribute ignored refill");
    fx(ad(3, 1, 6), 0, 0, "R4 repeat hits");
    mmu_on = 1;

    @(negedge clk);
    inv_all = 1;
    @(negedge clk);
    inv_all = 0;
    fx(ad(1, 0, 1), 1, 8, "R10 miss after invalidate");
    fx(ad(3, 1, 1), 1, 8, "R10 second line invalid");

    do_reset();
    gen = 0;
    set_en(1);
    for (int t = 0; t < 5; t++) fx(ad(t, 2, 0), 1, 8, "R9 fill set");
    fx(ad(1, 2, 3), 1, 0, "R9 second way kept");
    fx(ad(0, 2, 3), 1, 8, "R9 first way evicted");
    fx(ad(2, 2, 3), 1, 0, "R9 third way kept");
    fx(ad(1, 2, 3), 1, 8, "R9 pointer moved on");

    do_reset();
    set_en(1);
    rr_mode = 0;
    lock_mask = 4'b1011;
    fx(ad(0, 3, 0), 1, 8, "R8 fill X");
    fx(ad(1, 3, 0), 1, 8, "R8 fill Y");
    fx(ad(0, 3, 0), 1, 8, "R8 only one way usable");
    lock_mask = 4'hf;
    fx(ad(2, 3, 0), 1, 1, "R8 all locked single read");
    fx(ad(2, 3, 0), 1, 1, "R8 all locked no allocation");
    fx(ad(0, 3, 7), 1, 0, "R8 locked line still hits");

    do_reset();
    set_en(1);
    rr_mode = 1;
    lock_mask = 0;
    rr = 0;
    for (int s = 0; s < 4; s++) for (int w = 0; w < 4; w++) mval[s][w] = 0;
    for (int k = 0; k < 400; k++) begin
      int t, s, o, hw, v, en;
      bit c, effc;
      if (k % 50 == 0) lock_mask = 4'($urandom);
      mmu_on = 1'($urandom);
      c = 1'($urandom);
      t = $urandom % 6;
      s = $urandom % 4;
      o = $urandom % 8;
      a = ad(t, s, o);
      effc = !mmu_on || c;
      hw = -1;
      for (int w = 0; w < 4; w++) if (mval[s][w] && mtag[s][w] == t) hw = w;
      v = -1;
      for (int i = 0; i < 4; i++) if (v < 0 && !lock_mask[(rr + i) % 4]) v = (rr + i) % 4;
      if (!effc) en = 1;
      else if (hw >= 0) en = 0;
      else if (v < 0) en = 1;
      else begin
        en = 8;
        mval[s][v] = 1;
        mtag[s][v] = t;
        rr = (v + 1) % 4;
      end
      fetch(a, c, d, n, l);
      if (en == 0) chk(n == 0 && l == 0, "R5 random hit", n, 0);
      else if (en == 8) chk(n == 8, "R6 random refill", n, 8);
      else chk(n == 1, "R7 random single", n, 1);
      chk(d == mv(a), "R9 random data", d, mv(a));
    end
    chk(hold_bad == 0, "R11 request hold", hold_bad, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule